// File: doc/BRIEF.md
# Windowed CPU Activity and Energy Sampler

This block watches one processor core and its cache hierarchy over a repeating window of clock cycles. Each cycle it puts the core into exactly one of four states (active, stalled, idle, power-gated) and counts six kinds of cache traffic: line reads, word reads, line writes and word writes at the first level, and line reads and line writes at the second level. An external agent supplies, for the present operating point, a static and a dynamic energy-per-cycle coefficient for each core state and an energy cost for each cache event kind. The block only accumulates; it never derives coefficients.

When a window closes, all counts and a window energy figure are copied into output registers. A one-cycle valid strobe marks the copy, and counting restarts in the very next cycle, so no event is lost between windows. The energy figure is the sum over the window of the per-cycle cost: the selected state's static plus dynamic coefficient, plus the cost of every cache event that fired. Counters saturate, and a flag marks any window in which a counter or the energy total would have overflowed.

Top module: `win_energy_sampler`

## Requirements
- R1: While reset is asserted (rst_n low), snap_valid is 0 and every snapshot output (counts, energy, overflow flag) is 0.
- R2: A window lasts win_len cycles counted from reset release, and snap_valid is high for exactly the one cycle after each window's last cycle. A win_len of 0 behaves as 1, giving a strobe every cycle.
- R3: state_req bits are 0 active, 1 stall, 2 idle, 3 power-gated. Each cycle at most one state is counted, with priority gated over idle over stall over active. A cycle with no bit set counts in no state. The snapshot places the counts for states 0..3 at snap_state[CW*i +: CW].
- R4: Event strobe bits are 0 L1 line read, 1 L1 word read, 2 L1 line write, 3 L1 word write, 4 L2 line read, 5 L2 line write. Each set bit adds one to its count, placed at snap_event[CW*i +: CW].
- R5: snap_energy equals the sum, over the window's cycles, of coef_sta[i]+coef_dyn[i] for the counted state i plus ev_cost[j] for every set event bit j. Coefficient i sits at bits CFW*i +: CFW of its vector.
- R6: The snapshot includes the window's last cycle, and the next window starts from zero, so back-to-back windows lose and repeat no event.
- R7: A counter that reaches 2^CW-1 holds there. snap_ovf is 1 when any counter or the energy total would have exceeded its width during the window, and 0 otherwise.
- R8: Snapshot outputs stay unchanged between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_len | input | WINW | Window length in cycles |
| state_req | input | 4 | Core state indications, one bit per state |
| ev_strobe | input | 6 | Cache event strobes for this cycle |
| coef_sta | input | 4*CFW | Static energy per cycle, one field per state |
| coef_dyn | input | 4*CFW | Dynamic energy per cycle, one field per state |
| ev_cost | input | 6*CFW | Energy per cache event, one field per kind |
| snap_valid | output | 1 | One-cycle strobe: new snapshot available |
| snap_state | output | 4*CW | Cycle counts per core state |
| snap_event | output | 6*CW | Counts per cache event kind |
| snap_energy | output | EW | Window energy total |
| snap_ovf | output | 1 | Saturation occurred during the window |

## Verification
The sampler is driven with a pure active stream, with all sixteen combinations of state bits, with dense pseudo-random cache strobes, and with a rotating state plus counting event pattern. The full-combination pattern separates a correct priority order from any other order and shows that a no-state cycle is not charged. The event patterns show that each strobe lands in its own field and carries its own cost. Back-to-back windows, a one-cycle window, a zero-length window and a window longer than the counter range cover the restart, strobe-rate and saturation cases. The saturation run also confirms that the flag clears in the following clean window.

// File: rtl/win_energy_sampler.sv
module win_energy_sampler #(
  parameter int CW   = 16,
  parameter int WINW = 16,
  parameter int CFW  = 16,
  parameter int EW   = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WINW-1:0]   win_len,
  input  logic [3:0]        state_req,
  input  logic [5:0]        ev_strobe,
  input  logic [4*CFW-1:0]  coef_sta,
  input  logic [4*CFW-1:0]  coef_dyn,
  input  logic [6*CFW-1:0]  ev_cost,
  output logic              snap_valid,
  output logic [4*CW-1:0]   snap_state,
  output logic [6*CW-1:0]   snap_event,
  output logic [EW-1:0]     snap_energy,
  output logic              snap_ovf
);
  localparam int NS = 4;
  localparam int NE = 6;
  localparam logic [CW-1:0] CMAX = '1;

  logic [WINW-1:0] wcnt;
  logic [CW-1:0]   st_cnt [NS];
  logic [CW-1:0]   ev_cnt [NE];
  logic [CW-1:0]   st_nxt [NS];
  logic [CW-1:0]   ev_nxt [NE];
  logic [EW-1:0]   e_acc, e_add, e_nxt;
  logic [EW:0]     e_sum;
  logic            ovf_acc, sat_hit, ovf_nxt;
  logic [NS-1:0]   st_inc;
  logic            last;

  assign last = (win_len <= WINW'(1)) || (wcnt >= win_len - WINW'(1));

  always_comb begin
    st_inc = '0;
    if (state_req[3])      st_inc[3] = 1'b1;
    else if (state_req[2]) st_inc[2] = 1'b1;
    else if (state_req[1]) st_inc[1] = 1'b1;
    else if (state_req[0]) st_inc[0] = 1'b1;
  end

  always_comb begin
    sat_hit = 1'b0;
    e_add   = '0;
    for (int i = 0; i < NS; i++) begin
      st_nxt[i] = (st_inc[i] && st_cnt[i] != CMAX) ? st_cnt[i] + CW'(1) : st_cnt[i];
      if (st_inc[i]) begin
        if (st_cnt[i] == CMAX) sat_hit = 1'b1;
        e_add = e_add + EW'(coef_sta[i*CFW +: CFW]) + EW'(coef_dyn[i*CFW +: CFW]);
      end
    end
    for (int j = 0; j < NE; j++) begin
      ev_nxt[j] = (ev_strobe[j] && ev_cnt[j] != CMAX) ? ev_cnt[j] + CW'(1) : ev_cnt[j];
      if (ev_strobe[j]) begin
        if (ev_cnt[j] == CMAX) sat_hit = 1'b1;
        e_add = e_add + EW'(ev_cost[j*CFW +: CFW]);
      end
    end
  end

  assign e_sum   = {1'b0, e_acc} + {1'b0, e_add};
  assign e_nxt   = e_sum[EW] ? '1 : e_sum[EW-1:0];
  assign ovf_nxt = ovf_acc | sat_hit | e_sum[EW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt        <= '0;
      e_acc       <= '0;
      ovf_acc     <= 1'b0;
      snap_valid  <= 1'b0;
      snap_state  <= '0;
      snap_event  <= '0;
      snap_energy <= '0;
      snap_ovf    <= 1'b0;
      for (int i = 0; i < NS; i++) st_cnt[i] <= '0;
      for (int j = 0; j < NE; j++) ev_cnt[j] <= '0;
    end else begin
      snap_valid <= last;
      if (last) begin
        wcnt        <= '0;
        e_acc       <= '0;
        ovf_acc     <= 1'b0;
        snap_energy <= e_nxt;
        snap_ovf    <= ovf_nxt;
        for (int i = 0; i < NS; i++) begin
          snap_state[i*CW +: CW] <= st_nxt[i];
          st_cnt[i] <= '0;
        end
        for (int j = 0; j < NE; j++) begin
          snap_event[j*CW +: CW] <= ev_nxt[j];
          ev_cnt[j] <= '0;
        end
      end else begin
        wcnt    <= wcnt + WINW'(1);
        e_acc   <= e_nxt;
        ovf_acc <= ovf_nxt;
        for (int i = 0; i < NS; i++) st_cnt[i] <= st_nxt[i];
        for (int j = 0; j < NE; j++) ev_cnt[j] <= ev_nxt[j];
      end
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk) $past(!rst_n) |-> !snap_valid && snap_energy == '0);

  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    snap_valid |=> !snap_valid || $past(win_len) <= WINW'(1));

  a_r3_state_bound: assert property (@(posedge clk) disable iff (!rst_n)
    snap_valid && !snap_ovf |->
      (32'(snap_state[0 +: CW]) + 32'(snap_state[CW +: CW]) + 32'(snap_state[2*CW +: CW])
       + 32'(snap_state[3*CW +: CW])) <= ((win_len == '0) ? 32'd1 : 32'(win_len)));

  a_r5_zero_energy: assert property (@(posedge clk) disable iff (!rst_n)
    snap_valid && snap_state == '0 && snap_event == '0 |-> snap_energy == '0);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_valid |-> $stable(snap_energy) && $stable(snap_state) && $stable(snap_event));
endmodule

// File: tb/test_win_energy_sampler.sv
`timescale 1ns/1ps
module test_win_energy_sampler;
  localparam int CW = 8, WINW = 12, CFW = 16, EW = 32;
  localparam int CMAXI = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [WINW-1:0]  win_len = '0;
  logic [3:0]       state_req = '0;
  logic [5:0]       ev_strobe = '0;
  logic [4*CFW-1:0] coef_sta, coef_dyn;
  logic [6*CFW-1:0] ev_cost;
  logic             snap_valid, snap_ovf;
  logic [4*CW-1:0]  snap_state;
  logic [6*CW-1:0]  snap_event;
  logic [EW-1:0]    snap_energy;

  int errors = 0, checks = 0;
  int sta_v[4] = '{100, 80, 60, 5};
  int dyn_v[4] = '{300, 150, 20, 0};
  int cost_v[6] = '{7, 3, 9, 4, 25, 31};
  int exp_st[4];
  int exp_ev[6];
  longint exp_e;
  logic [EW-1:0] prev_e;

  always #2 clk = ~clk;

  win_energy_sampler #(.CW(CW), .WINW(WINW), .CFW(CFW), .EW(EW)) i_win_energy_sampler (
    .clk(clk), .rst_n(rst_n), .win_len(win_len), .state_req(state_req), .ev_strobe(ev_strobe),
    .coef_sta(coef_sta), .coef_dyn(coef_dyn), .ev_cost(ev_cost), .snap_valid(snap_valid),
    .snap_state(snap_state), .snap_event(snap_event), .snap_energy(snap_energy), .snap_ovf(snap_ovf));

  initial begin
    for (int i = 0; i < 4; i++) begin
      coef_sta[i*CFW +: CFW] = CFW'(sta_v[i]);
      coef_dyn[i*CFW +: CFW] = CFW'(dyn_v[i]);
    end
    for (int j = 0; j < 6; j++) ev_cost[j*CFW +: CFW] = CFW'(cost_v[j]);
  end

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [9:0] pat(int id, int k);
    case (id)
      0: return {6'b0, 4'b0001};
      1: return {6'b0, 4'(k)};
      2: return {6'((k * 11) ^ (k >> 1) ^ 6'h15), 4'b0000};
      default: return {6'(k), 4'(1 << (k % 4))};
    endcase
  endfunction

  task automatic do_reset(int len);
    rst_n = 1'b0; state_req = '0; ev_strobe = '0; win_len = WINW'(len);
    repeat (3) @(negedge clk);
    check("R1 valid in reset", snap_valid, 0);
    check("R1 energy in reset", snap_energy, 0);
    check("R1 counts in reset", {snap_state, snap_event, snap_ovf} == '0, 1);
    rst_n = 1'b1;
    prev_e = '0;
  endtask

  task automatic drive_window(int id, int n);
    logic [9:0] p;
    int sel;
    bit ovf = 0;
    for (int i = 0; i < 4; i++) exp_st[i] = 0;
    for (int j = 0; j < 6; j++) exp_ev[j] = 0;
    exp_e = 0;
    for (int k = 0; k < n; k++) begin
      if (k == 1) begin
        check("R2 strobe one cycle", snap_valid, 0);
        check("R8 snapshot held", snap_energy, prev_e);
      end
      p = pat(id, k);
      state_req = p[3:0];
      ev_strobe = p[9:4];
      sel = p[3] ? 3 : p[2] ? 2 : p[1] ? 1 : p[0] ? 0 : -1;
      if (sel >= 0) begin
        exp_st[sel]++;
        exp_e += sta_v[sel] + dyn_v[sel];
      end
      for (int j = 0; j < 6; j++) if (p[4+j]) begin
        exp_ev[j]++;
        exp_e += cost_v[j];
      end
      @(negedge clk);
    end
    check("R2 strobe at window end", snap_valid, 1);
    for (int i = 0; i < 4; i++) begin
      if (exp_st[i] > CMAXI) ovf = 1;
      check("R3 state count", snap_state[i*CW +: CW], (exp_st[i] > CMAXI) ? CMAXI : exp_st[i]);
    end
    for (int j = 0; j < 6; j++) begin
      if (exp_ev[j] > CMAXI) ovf = 1;
      check("R4 event count", snap_event[j*CW +: CW], (exp_ev[j] > CMAXI) ? CMAXI : exp_ev[j]);
    end
    check("R5 window energy", snap_energy, exp_e);
    check("R7 overflow flag", snap_ovf, ovf);
    prev_e = snap_energy;
  endtask

  task automatic t_active();   do_reset(10); drive_window(0, 10); endtask
  task automatic t_priority(); do_reset(16); drive_window(1, 16); endtask
  task automatic t_events();   do_reset(23); drive_window(2, 23); endtask
  task automatic t_back2back();
    do_reset(7);
    drive_window(3, 7);
    drive_window(3, 7);
    drive_window(1, 7);
    check("R6 restart from zero", snap_state[3*CW +: CW], 0);
  endtask
  task automatic t_short();
    do_reset(1);
    for (int r = 0; r < 3; r++) drive_window(3, 1);
    do_reset(0);
    drive_window(0, 1);
    drive_window(2, 1);
  endtask
  task automatic t_saturate();
    do_reset(300);
    drive_window(0, 300);
    drive_window(3, 300);
    state_req = '0; ev_strobe = '0;
    do_reset(12);
    drive_window(0, 12);
    check("R7 flag clears", snap_ovf, 0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_active();
    t_priority();
    t_events();
    t_back2back();
    t_short();
    t_saturate();
    state_req = '0; ev_strobe = '0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule